// File: doc/BRIEF.md
# PWM Compare Value Shadow and Update Controller

This block keeps the four 12-bit compare values that a PWM waveform generator uses. They are two dead times, SA and SB, and two on times, RA and RB. Software writes each value into a shadow register through a byte-wide write port. The generator reads only the active copies. The block moves shadow values into the active set only at the generator's end-of-cycle strobe, so a running cycle never mixes old and new values.

The configuration bits choose one of three update policies:

- **Auto-lock:** a transfer happens at the end of a cycle only if RB was the last compare value committed.
- **Manual lock:** a set lock bit holds all transfers back.
- **Immediate:** auto-lock and lock are both clear, and every end-of-cycle strobe applies the pending shadows.

A separate fifty-percent option drives the A pair from the B pair's shadows when a transfer happens.

Top module: `pwm_cmp_shadow`

## Requirements
- R1: After reset, all four active outputs and all four shadow values are zero.
- R2: A write with `wr_hi`=1 stages `wr_data[3:0]` as the upper four bits. A write with `wr_hi`=0 commits {staged bits, `wr_data`} into the shadow chosen by `wr_sel` (0=SA, 1=RA, 2=SB, 3=RB). A commit alone never changes an active output.
- R3: Active outputs change only on a clock edge that samples `eoc`=1. At every other edge they hold.
- R4: With `cfg_autolock`=1, an `eoc` transfers the shadows only when the last committed value was RB.
- R5: The RB-last condition is set by a commit to RB, cleared by a commit to SA, RA or SB, and cleared by a transfer.
- R6: With `cfg_autolock`=0 and `cfg_lock`=1, `eoc` transfers nothing.
- R7: With `cfg_autolock`=0 and `cfg_lock`=0, every `eoc` transfers all four shadows.
- R8: With `cfg_autolock`=1, `cfg_lock` has no effect.
- R9: With `cfg_fifty`=1, a transfer loads SA from the SB shadow and RA from the RB shadow, and the SA and RA shadows are ignored.
- R10: With `cfg_fifty`=0, a transfer loads each active value from its own shadow.
- R11: A commit in the same cycle as `eoc` is not part of that transfer. Its effect on the RB-last condition takes priority over the transfer's clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_hi | input | 1 | 1 = upper-bits write, 0 = low-byte commit |
| wr_sel | input | 2 | Target value: 0 SA, 1 RA, 2 SB, 3 RB |
| wr_data | input | 8 | Write data |
| cfg_autolock | input | 1 | Enables the RB-last transfer rule |
| cfg_lock | input | 1 | Holds transfers back when auto-lock is off |
| cfg_fifty | input | 1 | Fifty-percent mirroring of the B pair onto the A pair |
| eoc | input | 1 | End-of-cycle strobe from the generator |
| act_sa | output | 12 | Active first dead time |
| act_ra | output | 12 | Active first on time |
| act_sb | output | 12 | Active second dead time |
| act_rb | output | 12 | Active second on time |

## Verification
The assertions check on every cycle that:

- the active set holds unless a strobe-qualified transfer happens;
- a transfer copies the shadows exactly, or mirrors B onto A in fifty-percent mode;
- lock and a clear RB-last condition each block transfers;
- the RB-last condition follows commits and transfers, including its clearing by a transfer, which the ports cannot reveal.

Only the bench scenarios can show the following:

- the byte-pair assembly with its staging register;
- the ordering cases where a pending value appears several cycles later under a different policy;
- a commit that lands in the same cycle as the strobe and reaches the outputs only at the next one.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int N_CMP = 4;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    CMP_SA = 2'd0,
    CMP_RA = 2'd1,
    CMP_SB = 2'd2,
    CMP_RB = 2'd3
  } cmp_sel_e;

  // Transfer decision for one end-of-cycle strobe.
  function automatic logic xfer_decide(input logic eoc, input logic autolock,
                                       input logic lock, input logic rb_last);
    return eoc && (autolock ? rb_last : !lock);
  endfunction

  // Which shadow feeds a given active slot.
  function automatic logic [SEL_W-1:0] load_src(input logic [SEL_W-1:0] slot,
                                                input logic fifty);
    return (fifty && !slot[1]) ? {1'b1, slot[0]} : slot;
  endfunction
endpackage

// File: rtl/pcs_shadow_regs.sv
module pcs_shadow_regs
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_hi,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [N_CMP-1:0][VAL_W-1:0]  shadow,
  output logic                         commit,
  output logic [SEL_W-1:0]             commit_sel
);
  localparam int HI_W = VAL_W - BYTE_W;

  logic [HI_W-1:0] stage_q;

  assign commit     = wr_en && !wr_hi;
  assign commit_sel = wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (wr_en && wr_hi) stage_q <= wr_data[HI_W-1:0];
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow[i] <= '0;
      else if (commit && commit_sel == SEL_W'(i)) shadow[i] <= {stage_q, wr_data};
    end
  end
endmodule

// File: rtl/pcs_xfer_policy.sv
module pcs_xfer_policy
  import pwm_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SEL_W-1:0] commit_sel,
  input  logic             eoc,
  input  logic             cfg_autolock,
  input  logic             cfg_lock,
  output logic             xfer,
  output logic             rb_last
);
  assign xfer = xfer_decide(eoc, cfg_autolock, cfg_lock, rb_last);

  // A commit outranks the clear caused by a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rb_last <= 1'b0;
    else if (commit) rb_last <= (commit_sel == CMP_RB);
    else if (xfer)   rb_last <= 1'b0;
  end
endmodule

// File: rtl/pcs_active_bank.sv
module pcs_active_bank
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer,
  input  logic                         cfg_fifty,
  input  logic [N_CMP-1:0][VAL_W-1:0]  shadow,
  output logic [N_CMP-1:0][VAL_W-1:0]  active
);
  for (genvar i = 0; i < N_CMP; i++) begin : g_act
    logic [SEL_W-1:0] src;
    assign src = load_src(SEL_W'(i), cfg_fifty);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active[i] <= '0;
      else if (xfer) active[i] <= shadow[src];
    end
  end
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cfg_autolock,
  input  logic              cfg_lock,
  input  logic              cfg_fifty,
  input  logic              eoc,
  output logic [VAL_W-1:0]  act_sa,
  output logic [VAL_W-1:0]  act_ra,
  output logic [VAL_W-1:0]  act_sb,
  output logic [VAL_W-1:0]  act_rb
);
  logic [N_CMP-1:0][VAL_W-1:0] shadow_q;
  logic [N_CMP-1:0][VAL_W-1:0] active_q;
  logic                        commit;
  logic [SEL_W-1:0]            commit_sel;
  logic                        xfer;
  logic                        rb_last;

  pcs_shadow_regs #(.VAL_W(VAL_W), .BYTE_W(BYTE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_sel(wr_sel),
    .wr_data(wr_data), .shadow(shadow_q), .commit(commit), .commit_sel(commit_sel)
  );

  pcs_xfer_policy u_policy (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_sel(commit_sel), .eoc(eoc),
    .cfg_autolock(cfg_autolock), .cfg_lock(cfg_lock), .xfer(xfer), .rb_last(rb_last)
  );

  pcs_active_bank #(.VAL_W(VAL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .cfg_fifty(cfg_fifty),
    .shadow(shadow_q), .active(active_q)
  );

  assign act_sa = active_q[CMP_SA];
  assign act_ra = active_q[CMP_RA];
  assign act_sb = active_q[CMP_SB];
  assign act_rb = active_q[CMP_RB];
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_autolock,
  input logic                        cfg_lock,
  input logic                        cfg_fifty,
  input logic                        eoc,
  input logic                        commit,
  input logic [SEL_W-1:0]            commit_sel,
  input logic                        xfer,
  input logic                        rb_last,
  input logic [N_CMP-1:0][VAL_W-1:0] shadow,
  input logic [N_CMP-1:0][VAL_W-1:0] active
);
  // R3
  hold_without_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(active));
  // R3
  xfer_needs_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> eoc);
  // R4
  autolock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_autolock && !rb_last |=> $stable(active));
  // R6
  manual_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_autolock && cfg_lock |=> $stable(active));
  // R5
  rb_commit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_sel == CMP_RB |=> rb_last);
  // R5
  other_commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_sel != CMP_RB |=> !rb_last);
  // R5
  xfer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !commit |=> !rb_last);
  // R9
  fifty_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && cfg_fifty |=> active[CMP_SA] == active[CMP_SB] && active[CMP_RA] == active[CMP_RB]);
  // R10
  plain_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !cfg_fifty |=> active == $past(shadow));
  // R7
  immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc && !cfg_autolock && !cfg_lock |-> xfer);
endmodule

bind pwm_cmp_shadow pcs_checker #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_autolock(cfg_autolock), .cfg_lock(cfg_lock),
  .cfg_fifty(cfg_fifty), .eoc(eoc), .commit(commit), .commit_sel(commit_sel),
  .xfer(xfer), .rb_last(rb_last), .shadow(shadow_q), .active(active_q)
);

// File: tb/tb_pwm_cmp_shadow.sv
module tb_pwm_cmp_shadow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        cfg_autolock = 1'b0, cfg_lock = 1'b0, cfg_fifty = 1'b0, eoc = 1'b0;
  logic [11:0] act_sa, act_ra, act_sb, act_rb;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_cmp_shadow dut (.*);

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [11:0] sa, input logic [11:0] ra,
                         input logic [11:0] sb, input logic [11:0] rb);
    chk({tag, " SA"}, act_sa, sa);
    chk({tag, " RA"}, act_ra, ra);
    chk({tag, " SB"}, act_sb, sb);
    chk({tag, " RB"}, act_rb, rb);
  endtask

  // Upper bits, then a low-byte commit; with_eoc raises eoc on the commit cycle.
  task automatic put(input logic [1:0] sel, input logic [11:0] v, input bit with_eoc = 0);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_sel = sel; wr_data = {4'h0, v[11:8]};
    @(negedge clk); wr_hi = 0; wr_data = v[7:0]; eoc = with_eoc;
    @(negedge clk); wr_en = 0; eoc = 0;
  endtask

  task automatic strobe();
    @(negedge clk); eoc = 1;
    @(negedge clk); eoc = 0;
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 12'h0, 12'h0, 12'h0, 12'h0);
  endtask

  task automatic t_immediate();
    cfg_autolock = 0; cfg_lock = 0; cfg_fifty = 0;
    put(2'd0, 12'h123); put(2'd1, 12'h456); put(2'd2, 12'h789); put(2'd3, 12'hABC);
    chk_all("R2 R3 no eoc yet", 12'h0, 12'h0, 12'h0, 12'h0);
    strobe();
    chk_all("R7 R10 immediate", 12'h123, 12'h456, 12'h789, 12'hABC);
  endtask

  task automatic t_manual_lock();
    cfg_lock = 1;
    put(2'd0, 12'h111);
    strobe();
    chk("R6 locked SA", act_sa, 12'h123);
    cfg_lock = 0;
    @(negedge clk);
    chk("R3 unlocked, no eoc", act_sa, 12'h123);
    strobe();
    chk("R7 after unlock", act_sa, 12'h111);
  endtask

  task automatic t_autolock();
    cfg_autolock = 1;
    put(2'd3, 12'h222); put(2'd0, 12'h333);
    strobe();
    chk("R4 R5 SA after non-RB last", act_sa, 12'h111);
    chk("R4 R5 RB after non-RB last", act_rb, 12'hABC);
    put(2'd3, 12'h444);
    strobe();
    chk_all("R4 RB last", 12'h333, 12'h456, 12'h789, 12'h444);
  endtask

  task automatic t_lock_ignored();
    cfg_lock = 1;
    put(2'd3, 12'h777);
    strobe();
    chk("R8 lock ignored", act_rb, 12'h777);
    cfg_lock = 0;
  endtask

  task automatic t_same_cycle();
    put(2'd3, 12'h100);
    put(2'd3, 12'h200, 1);
    chk("R11 old value applied", act_rb, 12'h100);
    strobe();
    chk("R11 flag kept by commit", act_rb, 12'h200);
  endtask

  task automatic t_fifty();
    cfg_autolock = 0; cfg_lock = 0; cfg_fifty = 1;
    put(2'd0, 12'hAAA); put(2'd2, 12'h0F0); put(2'd3, 12'h1E1);
    strobe();
    chk_all("R9 fifty", 12'h0F0, 12'h1E1, 12'h0F0, 12'h1E1);
    cfg_fifty = 0;
    strobe();
    chk_all("R10 independent", 12'hAAA, 12'h456, 12'h0F0, 12'h1E1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_manual_lock();
    t_autolock();
    t_lock_ignored();
    t_same_cycle();
    t_fifty();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule